// File: doc/BRIEF.md
# Pause and Priority Flow Control Frame Generator

This block builds Ethernet MAC control frames that ask a link partner to stop or resume sending, and streams them to the transmit path one byte per accepted cycle. In link-level mode it builds a classic PAUSE frame from a two-bit stop/resume request. In priority mode it builds a priority flow control frame from a vector of two-bit requests, one pair per priority queue. The number of queues is a parameter from 2 to 8.

Requests are held pending until a frame carrying them starts. A request that arrives while a frame is being sent waits and goes out in a later frame. After a frame with a stop request (XOFF) starts, a programmable holdoff counter counts down on an external quantum tick. While it is non-zero, no further XOFF is sent. Resume requests (XON) are never held back. Every frame is 60 bytes, padded with zeros. The frame check sequence is appended downstream, and arbitration against client traffic is also done downstream.

Top module: `flowctl_frame_gen`

## Requirements
- R1: While and after reset, with no request pending, `out_valid` is 0.
- R2: Every frame is exactly 60 bytes. `out_sop` marks the first byte and `out_eop` marks the 60th byte.
- R3: Bytes 0-5 carry 01 80 C2 00 00 01. Bytes 6-11 carry `cfg_src_addr` with the most significant byte first. Bytes 12-13 carry 88 08.
- R4: With `cfg_pfc_en`=0, a frame carries opcode bytes 00 01 at bytes 14-15. It carries a 16-bit quanta value at bytes 16-17, most significant byte first. The quanta value is `cfg_pause_quanta` for an XOFF request (`link_req`=2'b01) and zero for an XON request (`link_req`=2'b10). Bytes 18-59 are zero.
- R5: With `cfg_pfc_en`=1, a frame carries opcode bytes 01 01, byte 16 = 00 and byte 17 = the class-enable vector (bit k set when queue k has a request in the frame). Bytes 18+2k and 19+2k carry queue k's quanta, most significant byte first. Bytes 34-59 are zero, and so are unrequested classes.
- R6: The encoding of each two-bit request field (`link_req`, or `pfc_req[2k+1:2k]` for queue k) is: 01 requests XOFF, 10 requests XON, and 00 and 11 are no request. A newer request to the same slot replaces an older pending one. A priority XOFF carries that queue's 16-bit field of `cfg_pfc_quanta`; an XON carries zero.
- R7: `pfc_req` is ignored while `cfg_pfc_en`=0, and `link_req` is ignored while `cfg_pfc_en`=1. An ignored request produces no frame, either at once or later.
- R8: After a frame carrying an XOFF starts, no other frame carrying an XOFF starts until `cfg_holdoff` cycles of `quanta_tick` have been seen. A frame carrying only XON requests is not held back.
- R9: A request captured while a frame is being sent is kept, and its frame starts after the current frame's last byte.
- R10: While `out_valid` is 1 and `out_ready` is 0, the output byte and the markers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pfc_en | input | 1 | 1 selects priority frames, 0 selects link PAUSE frames |
| cfg_src_addr | input | 48 | Source MAC address |
| cfg_pause_quanta | input | 16 | Quanta value for link-level XOFF |
| cfg_pfc_quanta | input | 16*NUM_Q | Per-queue XOFF quanta, queue k in bits 16k+15:16k |
| cfg_holdoff | input | HOLD_W | Quantum ticks between consecutive XOFF frames |
| quanta_tick | input | 1 | One pulse per pause quantum (512 bit times) |
| link_req | input | 2 | Link-level request: 01 XOFF, 10 XON |
| pfc_req | input | 2*NUM_Q | Per-queue request pairs |
| out_ready | input | 1 | Downstream accepts the byte |
| out_valid | output | 1 | Byte on `out_data` is valid |
| out_data | output | 8 | Frame byte |
| out_sop | output | 1 | First byte of frame |
| out_eop | output | 1 | Last byte of frame |

## Verification
A request sampled at clock edge t becomes pending at t. The frame starts at edge t+1, so `out_valid` and byte 0 are visible before edge t+2. The bench drives requests for one cycle, allows a short window for `out_valid`, and samples every output on the falling edge, where all outputs are settled register values. Each byte counts as delivered at the rising edge that follows a falling-edge sample showing valid and ready. Holdoff release is due one edge after the final tick clears the counter. The bench therefore checks for silence after each partial tick count, and for a frame within a few cycles after the last tick.

// File: rtl/fcg_pkg.sv
package fcg_pkg;
   localparam int          FRAME_BYTES = 60;
   localparam int          MAX_CLASSES = 8;
   localparam int          QUANTA_W    = 16;
   localparam logic [47:0] CTRL_DA     = 48'h0180_C200_0001;
   localparam logic [15:0] CTRL_TYPE   = 16'h8808;
   localparam logic [15:0] OP_LINK     = 16'h0001;
   localparam logic [15:0] OP_PRIO     = 16'h0101;

   typedef enum logic [1:0] {
      REQ_NONE = 2'b00,
      REQ_XOFF = 2'b01,
      REQ_XON  = 2'b10,
      REQ_BAD  = 2'b11
   } req_code_t;

   typedef enum logic {
      SER_IDLE = 1'b0,
      SER_SEND = 1'b1
   } ser_state_t;
endpackage

// File: rtl/fcg_req_latch.sv
module fcg_req_latch #(
   parameter int SLOTS = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cap_en,
   input  logic [2*SLOTS-1:0] req,
   input  logic [SLOTS-1:0]   clr,
   output logic [SLOTS-1:0]   pend_xoff,
   output logic [SLOTS-1:0]   pend_xon
);
   import fcg_pkg::*;

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic xoff_q;
      logic xon_q;
      req_code_t code;
      assign code = req_code_t'(req[2*s +: 2]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            xoff_q <= 1'b0;
            xon_q  <= 1'b0;
         end else begin
            if (clr[s]) begin
               xoff_q <= 1'b0;
               xon_q  <= 1'b0;
            end
            if (cap_en) begin
               case (code)
                  REQ_XOFF: begin
                     xoff_q <= 1'b1;
                     xon_q  <= 1'b0;
                  end
                  REQ_XON: begin
                     xoff_q <= 1'b0;
                     xon_q  <= 1'b1;
                  end
                  default: ;
               endcase
            end
         end
      end

      assign pend_xoff[s] = xoff_q;
      assign pend_xon[s]  = xon_q;
   end
endmodule

// File: rtl/fcg_holdoff.sv
module fcg_holdoff #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          tick,
   output logic          clear
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (tick && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign clear = (cnt_q == '0);
endmodule

// File: rtl/fcg_serializer.sv
module fcg_serializer
   import fcg_pkg::*;
(
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             start,
   input  logic                             in_prio,
   input  logic [MAX_CLASSES-1:0]           in_cev,
   input  logic [MAX_CLASSES*QUANTA_W-1:0]  in_quanta,
   input  logic [47:0]                      in_sa,
   input  logic                             ready,
   output logic                             valid,
   output logic [7:0]                       data,
   output logic                             sop,
   output logic                             eop,
   output logic                             busy
);
   localparam int             IW       = $clog2(FRAME_BYTES);
   localparam logic [IW-1:0]  IDX_LAST = IW'(FRAME_BYTES - 1);
   localparam int             PRIO_END = 18 + 2*MAX_CLASSES;

   ser_state_t                      state_q;
   logic [IW-1:0]                   idx_q;
   logic                            prio_q;
   logic [MAX_CLASSES-1:0]          cev_q;
   logic [MAX_CLASSES*QUANTA_W-1:0] quanta_q;
   logic [47:0]                     sa_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= SER_IDLE;
         idx_q    <= '0;
         prio_q   <= 1'b0;
         cev_q    <= '0;
         quanta_q <= '0;
         sa_q     <= '0;
      end else begin
         case (state_q)
            SER_IDLE: begin
               if (start) begin
                  state_q  <= SER_SEND;
                  idx_q    <= '0;
                  prio_q   <= in_prio;
                  cev_q    <= in_cev;
                  quanta_q <= in_quanta;
                  sa_q     <= in_sa;
               end
            end
            default: begin
               if (ready) begin
                  if (idx_q == IDX_LAST) begin
                     state_q <= SER_IDLE;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end
            end
         endcase
      end
   end

   always_comb begin
      int b;
      int k;
      logic [15:0] op;
      b    = int'(idx_q);
      k    = 0;
      op   = prio_q ? OP_PRIO : OP_LINK;
      data = 8'h00;
      if (b < 6) begin
         data = CTRL_DA[8*(5-b) +: 8];
      end else if (b < 12) begin
         data = sa_q[8*(11-b) +: 8];
      end else if (b == 12) begin
         data = CTRL_TYPE[15:8];
      end else if (b == 13) begin
         data = CTRL_TYPE[7:0];
      end else if (b == 14) begin
         data = op[15:8];
      end else if (b == 15) begin
         data = op[7:0];
      end else if (prio_q) begin
         if (b == 17) begin
            data = cev_q;
         end else if ((b >= 18) && (b < PRIO_END)) begin
            k    = (b - 18) / 2;
            data = b[0] ? quanta_q[QUANTA_W*k +: 8] : quanta_q[QUANTA_W*k + 8 +: 8];
         end
      end else begin
         if (b == 16) begin
            data = quanta_q[15:8];
         end else if (b == 17) begin
            data = quanta_q[7:0];
         end
      end
   end

   assign valid = (state_q == SER_SEND);
   assign busy  = (state_q == SER_SEND);
   assign sop   = valid && (idx_q == '0);
   assign eop   = valid && (idx_q == IDX_LAST);
endmodule

// File: rtl/flowctl_frame_gen.sv
module flowctl_frame_gen
   import fcg_pkg::*;
#(
   parameter int NUM_Q  = 4,
   parameter int HOLD_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_pfc_en,
   input  logic [47:0]              cfg_src_addr,
   input  logic [15:0]              cfg_pause_quanta,
   input  logic [16*NUM_Q-1:0]      cfg_pfc_quanta,
   input  logic [HOLD_W-1:0]        cfg_holdoff,
   input  logic                     quanta_tick,
   input  logic [1:0]               link_req,
   input  logic [2*NUM_Q-1:0]       pfc_req,
   input  logic                     out_ready,
   output logic                     out_valid,
   output logic [7:0]               out_data,
   output logic                     out_sop,
   output logic                     out_eop
);
   localparam int QV_W = MAX_CLASSES * QUANTA_W;

   initial begin
      assert (NUM_Q >= 2 && NUM_Q <= MAX_CLASSES)
         else $error("NUM_Q must lie in 2..%0d", MAX_CLASSES);
      assert (HOLD_W >= 1)
         else $error("HOLD_W must be positive");
   end

   logic             lnk_xoff, lnk_xon, lnk_clr;
   logic [NUM_Q-1:0] prio_xoff, prio_xon, prio_clr;
   logic             hold_ok, busy, start, xoff_go;

   fcg_req_latch #(.SLOTS(1)) u_link_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_en    (!cfg_pfc_en),
      .req       (link_req),
      .clr       (lnk_clr),
      .pend_xoff (lnk_xoff),
      .pend_xon  (lnk_xon)
   );

   fcg_req_latch #(.SLOTS(NUM_Q)) u_prio_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_en    (cfg_pfc_en),
      .req       (pfc_req),
      .clr       (prio_clr),
      .pend_xoff (prio_xoff),
      .pend_xon  (prio_xon)
   );

   fcg_holdoff #(.CW(HOLD_W)) u_holdoff (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (xoff_go),
      .load_val (cfg_holdoff),
      .tick     (quanta_tick),
      .clear    (hold_ok)
   );

   logic [NUM_Q-1:0] prio_xoff_ok, prio_sel;
   logic             lnk_xoff_ok, lnk_sel;

   assign prio_xoff_ok = prio_xoff & {NUM_Q{hold_ok}};
   assign prio_sel     = prio_xoff_ok | prio_xon;
   assign lnk_xoff_ok  = lnk_xoff & hold_ok;
   assign lnk_sel      = lnk_xoff_ok | lnk_xon;

   assign start    = !busy && (cfg_pfc_en ? (|prio_sel) : lnk_sel);
   assign xoff_go  = start && (cfg_pfc_en ? (|prio_xoff_ok) : lnk_xoff_ok);
   assign lnk_clr  = start && !cfg_pfc_en;
   assign prio_clr = (start && cfg_pfc_en) ? prio_sel : '0;

   logic [QV_W-1:0]        prio_qv, link_qv, sel_qv;
   logic [MAX_CLASSES-1:0] prio_cev;

   for (genvar c = 0; c < MAX_CLASSES; c++) begin : g_class
      if (c < NUM_Q) begin : g_used
         assign prio_qv[QUANTA_W*c +: QUANTA_W] =
            prio_xoff_ok[c] ? cfg_pfc_quanta[16*c +: 16] : '0;
         assign prio_cev[c] = prio_sel[c];
      end else begin : g_unused
         assign prio_qv[QUANTA_W*c +: QUANTA_W] = '0;
         assign prio_cev[c] = 1'b0;
      end
   end

   assign link_qv = {{(QV_W-QUANTA_W){1'b0}}, (lnk_xoff_ok ? cfg_pause_quanta : 16'h0000)};
   assign sel_qv  = cfg_pfc_en ? prio_qv : link_qv;

   fcg_serializer u_ser (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .in_prio   (cfg_pfc_en),
      .in_cev    (cfg_pfc_en ? prio_cev : '0),
      .in_quanta (sel_qv),
      .in_sa     (cfg_src_addr),
      .ready     (out_ready),
      .valid     (out_valid),
      .data      (out_data),
      .sop       (out_sop),
      .eop       (out_eop),
      .busy      (busy)
   );
endmodule

// File: rtl/fcg_checker.sv
module fcg_checker
   import fcg_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       out_valid,
   input logic       out_ready,
   input logic [7:0] out_data,
   input logic       out_sop,
   input logic       out_eop
);
   logic [6:0] seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= '0;
      end else if (out_valid && out_ready) begin
         seen_q <= out_eop ? 7'd0 : seen_q + 7'd1;
      end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_idle_in_reset_R1: assert (!out_valid);
      end
   end

   assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)));

   assert_sop_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_sop |-> (out_valid && seen_q == 7'd0));

   assert_eop_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_eop == (seen_q == 7'(FRAME_BYTES - 1))));

   assert_da_lead_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && seen_q == 7'd0) |-> (out_data == 8'h01));

   assert_type_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && seen_q == 7'd12) |-> (out_data == 8'h88));
endmodule

bind flowctl_frame_gen fcg_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .out_sop   (out_sop),
   .out_eop   (out_eop)
);

// File: tb/sim_flowctl_frame_gen.sv
`timescale 1ns/1ps
module sim_flowctl_frame_gen;
   localparam int NQ = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_pfc_en = 1'b0;
   logic [47:0]       cfg_src_addr = 48'h0012_3456_789A;
   logic [15:0]       cfg_pause_quanta = 16'h1234;
   logic [16*NQ-1:0]  cfg_pfc_quanta = 64'hD004_C003_B002_A001;
   logic [15:0]       cfg_holdoff = 16'd0;
   logic              quanta_tick = 1'b0;
   logic [1:0]        link_req = 2'b00;
   logic [2*NQ-1:0]   pfc_req = '0;
   logic              out_ready = 1'b1;
   logic              out_valid;
   logic [7:0]        out_data;
   logic              out_sop, out_eop;

   int n_chk = 0;
   int n_fail = 0;
   int rc = 0;

   always #5 clk = ~clk;

   flowctl_frame_gen #(.NUM_Q(NQ), .HOLD_W(16)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_pfc_en(cfg_pfc_en), .cfg_src_addr(cfg_src_addr),
      .cfg_pause_quanta(cfg_pause_quanta), .cfg_pfc_quanta(cfg_pfc_quanta),
      .cfg_holdoff(cfg_holdoff), .quanta_tick(quanta_tick), .link_req(link_req),
      .pfc_req(pfc_req), .out_ready(out_ready), .out_valid(out_valid),
      .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop));

   logic [7:0] fb [60];
   bit         sop_ok, eop_ok, stall_ok;

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_byte(input int b, input bit prio, input logic [47:0] sa,
                                           input logic [7:0] cev, input logic [127:0] q);
      logic [47:0] da = 48'h0180C2000001;
      if (b < 6)  return da[47-8*b -: 8];
      if (b < 12) return sa[47-8*(b-6) -: 8];
      if (b == 12) return 8'h88;
      if (b == 13) return 8'h08;
      if (b == 14) return prio ? 8'h01 : 8'h00;
      if (b == 15) return 8'h01;
      if (!prio) begin
         if (b == 16) return q[15:8];
         if (b == 17) return q[7:0];
         return 8'h00;
      end
      if (b == 16) return 8'h00;
      if (b == 17) return cev;
      if (b < 34) return ((b - 18) % 2 == 0) ? q[16*((b-18)/2) + 8 +: 8] : q[16*((b-18)/2) +: 8];
      return 8'h00;
   endfunction

   task automatic pulse_link(input logic [1:0] v);
      @(negedge clk); link_req = v;
      @(negedge clk); link_req = 2'b00;
   endtask

   task automatic pulse_pfc(input logic [2*NQ-1:0] v);
      @(negedge clk); pfc_req = v;
      @(negedge clk); pfc_req = '0;
   endtask

   task automatic tick();
      @(negedge clk); quanta_tick = 1'b1;
      @(negedge clk); quanta_tick = 1'b0;
   endtask

   task automatic expect_none(input int n, input string req);
      bit seen = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         out_ready = 1'b1;
         if (out_valid) seen = 1;
      end
      check(!seen, req, "unexpected frame", seen, 0);
   endtask

   // Collects one frame; optionally injects two link requests at cycles inj, inj+1.
   task automatic get_frame(input string req, input int inj, input logic [1:0] v1, input logic [1:0] v2);
      int  nb = 0, cyc = 0, wait_c = 0;
      bit  prev_stall = 0, done = 0;
      logic [7:0] prev_d = 0;
      sop_ok = 1; eop_ok = 1; stall_ok = 1;
      while (!done && cyc < 400) begin
         @(negedge clk);
         if (inj >= 0) begin
            if (cyc == inj) link_req = v1;
            else if (cyc == inj + 1) link_req = v2;
            else if (cyc == inj + 2) link_req = 2'b00;
         end
         rc++;
         out_ready = (rc % 4) != 2;
         if (prev_stall && (!out_valid || out_data != prev_d)) stall_ok = 0;
         if (out_valid) begin
            cyc++;
            prev_stall = !out_ready;
            prev_d = out_data;
            if (out_ready) begin
               if (out_sop != (nb == 0)) sop_ok = 0;
               if (out_eop != (nb == 59)) eop_ok = 0;
               if (nb < 60) fb[nb] = out_data;
               nb++;
               if (out_eop) done = 1;
            end
         end else begin
            prev_stall = 0;
            if (nb == 0) begin
               wait_c++;
               if (wait_c > 20) cyc = 400;
            end
         end
      end
      out_ready = 1'b1;
      check(nb == 60, req, "frame byte count", nb, 60);
      check(sop_ok && eop_ok, "R2", "sop/eop placement", {sop_ok, eop_ok}, 2'b11);
      check(stall_ok, "R10", "hold under stall", stall_ok, 1);
   endtask

   task automatic cmp_frame(input string req, input bit prio, input logic [7:0] cev, input logic [127:0] q);
      int bad = -1;
      logic [7:0] e;
      for (int b = 59; b >= 0; b--) begin
         e = exp_byte(b, prio, cfg_src_addr, cev, q);
         if (fb[b] !== e) bad = b;
      end
      if (bad >= 0) begin
         e = exp_byte(bad, prio, cfg_src_addr, cev, q);
         check(0, req, $sformatf("byte %0d", bad), fb[bad], e);
      end else begin
         check(1, req, "frame content", 0, 0);
      end
   endtask

   initial begin
      int wd = 0;
      while (wd < 150000) begin
         @(posedge clk);
         wd++;
      end
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [7:0]   cev;
      logic [127:0] q;
      bit           any;
      repeat (3) @(negedge clk);
      check(!out_valid, "R1", "valid in reset", out_valid, 0);
      rst_n = 1'b1;
      expect_none(5, "R1");

      // R4 / R3: link XOFF and XON with two source addresses
      pulse_link(2'b01); get_frame("R4", -1, 0, 0); cmp_frame("R4", 0, 0, {112'b0, 16'h1234});
      cfg_src_addr = 48'hA1B2_C3D4_E5F6; cfg_pause_quanta = 16'hFFFF;
      pulse_link(2'b01); get_frame("R3", -1, 0, 0); cmp_frame("R3", 0, 0, {112'b0, 16'hFFFF});
      pulse_link(2'b10); get_frame("R4", -1, 0, 0); cmp_frame("R4", 0, 0, 128'h0);
      pulse_link(2'b11); expect_none(6, "R6");

      // R9 and R6 override: XOFF then XON during a frame -> only one XON frame follows
      cfg_pause_quanta = 16'h0042;
      pulse_link(2'b01);
      get_frame("R9", 20, 2'b01, 2'b10); cmp_frame("R9", 0, 0, {112'b0, 16'h0042});
      get_frame("R9", -1, 0, 0); cmp_frame("R6", 0, 0, 128'h0);
      expect_none(8, "R6");

      // R8 holdoff
      cfg_holdoff = 16'd3;
      pulse_link(2'b01); get_frame("R8", -1, 0, 0); cmp_frame("R8", 0, 0, {112'b0, 16'h0042});
      pulse_link(2'b01); expect_none(10, "R8");
      tick(); tick(); expect_none(6, "R8");
      tick(); get_frame("R8", -1, 0, 0); cmp_frame("R8", 0, 0, {112'b0, 16'h0042});
      pulse_link(2'b10); get_frame("R8", -1, 0, 0); cmp_frame("R8", 0, 0, 128'h0);
      tick(); tick(); tick();
      cfg_holdoff = 16'd0;

      // R7 mode gating
      pulse_pfc(8'h55); expect_none(8, "R7");
      cfg_pfc_en = 1'b1;
      pulse_link(2'b01); expect_none(8, "R7");
      cfg_pfc_en = 1'b0; expect_none(8, "R7");
      cfg_pfc_en = 1'b1;

      // R5 / R6 sweep over every request vector for four queues
      for (int v = 0; v < 256; v++) begin
         cev = 0; q = 0; any = 0;
         for (int k = 0; k < NQ; k++) begin
            if (v[2*k +: 2] == 2'b01) begin
               cev[k] = 1; any = 1; q[16*k +: 16] = cfg_pfc_quanta[16*k +: 16];
            end else if (v[2*k +: 2] == 2'b10) begin
               cev[k] = 1; any = 1;
            end
         end
         pulse_pfc(8'(v));
         if (any) begin
            get_frame("R5", -1, 0, 0);
            cmp_frame("R5", 1, cev, q);
         end else begin
            expect_none(5, "R6");
         end
      end

      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule